// File: doc/BRIEF.md
# Flash Write-Status Polling Bit Generator

This block models the device side of the status bit that a parallel NOR flash returns on its most significant data line while an internal program or erase runs. Command decoding lives elsewhere. When it accepts a program command, it sends a one-cycle start pulse together with the target address and the bit 7 of the datum. When it accepts an erase command, it sends a start pulse with a one-hot mask of the selected sectors. The embedded algorithm reports completion with a done pulse. A level input requests erase suspend.

While an operation is under way, the block decides on each read whether to return status or array data. It returns status only when the read address matches the program address, or when it falls in a sector chosen for erase. The status value follows a fixed rule. A running program shows the inverse of its bit 7. A running erase shows 0. A suspended erase shows 1. When an operation ends, the block shows the final value: the programmed bit for a program, 1 for an erase. A program aimed at a protected sector does not run. Neither does an erase whose selected sectors are all protected. In both cases the block holds a busy window of fixed length, set by a parameter in clock cycles, and then returns to array reads. The erase mask sent on to the algorithm leaves out protected sectors.

Top module: `flash_dq7_status`

## Requirements
- R1: While reset is low, and in the first cycle after it, busy_o, status_sel_o and erase_sect_o are all 0 and dq7_o is 1.
- R2: In the cycle after a program start is accepted, busy_o is 1. A read at the program address then gives status_sel_o=1 with dq7_o equal to the inverse of the programmed bit 7. Any other address gives status_sel_o=0.
- R3: In the cycle after algo_done ends a program, busy_o and status_sel_o are 0 and dq7_o equals the programmed bit 7.
- R4: During an erase, a read in a selected sector gives status_sel_o=1 and dq7_o=0. A read in an unselected sector gives status_sel_o=0. The sector is the top SECT_W bits of the address.
- R5: In the cycle after algo_done ends an erase, busy_o is 0 and dq7_o is 1.
- R6: Holding suspend_i high during a real erase enters suspend in the next cycle. In suspend, busy_o is 0 and selected sectors read status 1. Dropping suspend_i resumes the erase, and selected sectors read 0 again.
- R7: A program started in suspend follows the R2 rule at its address, and other selected sectors read 1. Its algo_done returns the block to suspend, and dq7_o then shows the programmed bit.
- R8: With no operation active, status_sel_o is 0 for every read address.
- R9: A program whose target sector is protected keeps busy_o high for exactly PROG_PROT_CYC cycles and ignores algo_done. It then returns to idle with dq7_o unchanged.
- R10: An erase whose selected sectors are all protected keeps busy_o high for exactly ERASE_PROT_CYC cycles and ignores suspend_i. It then returns to idle.
- R11: An erase with only some selected sectors protected drives erase_sect_o with the selected, unprotected sectors. Selected protected sectors still read status 0. The erase ends only on algo_done.
- R12: Start pulses received while a program or erase is busy are ignored. erase_sect_o and the captured program address do not change. If both start pulses arrive together in idle, the program wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start_i | input | 1 | Program command accepted (last write strobe done) |
| prog_addr_i | input | ADDR_W | Program target address |
| prog_d7_i | input | 1 | Bit 7 of the datum being programmed |
| erase_start_i | input | 1 | Erase command accepted |
| erase_sel_i | input | 2**SECT_W | One-hot mask of the sectors chosen for erase |
| algo_done_i | input | 1 | Embedded algorithm finished |
| suspend_i | input | 1 | Erase suspend request (level) |
| sect_prot_i | input | 2**SECT_W | Per-sector protection flags |
| rd_addr_i | input | ADDR_W | Current read address |
| busy_o | output | 1 | Operation or protected window running |
| status_sel_o | output | 1 | 1: drive status on bit 7; 0: array data |
| dq7_o | output | 1 | Status bit, or the final value of the last operation |
| erase_sect_o | output | 2**SECT_W | Sectors the algorithm must erase |

## Verification
The assertions check on every cycle that a start accepted in idle raises busy, that a running erase never shows 1 on a status read, that suspend never reports busy, and that a program never turns into an erase. They also check that an erase accepted in idle publishes exactly the unprotected part of its selection, that a protected-erase window never enters suspend, and that a finished erase shows 1. Only the bench scenarios can show the exact lengths of the protected windows, the per-address complement rule with its return to the true datum, the nesting of a program inside suspend, and that commands arriving mid-operation leave the captured address untouched.

// File: rtl/flash_dq7_pkg.sv
// Shared types for the write-status polling bit generator.
// Assumes: one operation at a time, plus one program nested in erase suspend.
package flash_dq7_pkg;

    // Operation phase of the status generator
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // no operation, array reads
        ST_PROG  = 3'd1,  // program (real or protected window)
        ST_ERASE = 3'd2,  // erase (real or protected window)
        ST_ESUSP = 3'd3,  // erase suspended
        ST_SPROG = 3'd4   // program while erase suspended
    } op_state_e;

    // True for phases that keep the internal algorithm busy
    function automatic logic phase_busy(input op_state_e s);
        return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_SPROG);
    endfunction

    // True for phases that keep an erase context alive
    function automatic logic phase_erasing(input op_state_e s);
        return (s == ST_ERASE) || (s == ST_ESUSP) || (s == ST_SPROG);
    endfunction

endpackage

// File: rtl/dq7_prot_timer.sv
// Down-counter that times the fixed busy window for a protected target.
// Loading a non-zero length starts the window. active_o stays high until
// the count runs out, and expire_o marks the final cycle of the window.
// Assumes: len_i is at least 1 when load_i is high.
module dq7_prot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             active_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Window flags decoded from the count
    always_comb begin
        active_o = (cnt_q != '0);
        expire_o = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    end

endmodule

// File: rtl/dq7_op_ctrl.sv
// Operation sequencer for the polling bit generator. It captures the
// program target and datum bit, the erase selection and its unprotected
// part, and it steps through idle, program, erase, suspend and nested
// program. It asks the timer for a fixed window when the target is protected.
// Assumes: start pulses last one cycle; suspend_i is a level.
module dq7_op_ctrl
    import flash_dq7_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3,
    parameter int NSECT  = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic              prog_d7_i,
    input  logic              erase_start_i,
    input  logic [NSECT-1:0]  erase_sel_i,
    input  logic              algo_done_i,
    input  logic              suspend_i,
    input  logic [NSECT-1:0]  sect_prot_i,
    input  logic              timer_act_i,
    input  logic              timer_exp_i,
    output op_state_e         state_o,
    output logic [ADDR_W-1:0] paddr_o,
    output logic              pd7_o,
    output logic [NSECT-1:0]  esel_o,
    output logic [NSECT-1:0]  emask_o,
    output logic              last_o,
    output logic              tload_o,
    output logic              tlen_erase_o
);

    localparam int SLO = ADDR_W - SECT_W;

    op_state_e         st_q, st_d;
    logic [ADDR_W-1:0] paddr_q;
    logic              pd7_q;
    logic [NSECT-1:0]  esel_q, emask_q;
    logic              last_q;
    logic              cap_prog, cap_erase, fin_prog, fin_erase;
    logic              prog_prot;
    logic [NSECT-1:0]  erase_live;

    // Protection lookups for an incoming command
    always_comb begin
        prog_prot  = sect_prot_i[prog_addr_i[ADDR_W-1:SLO]];
        erase_live = erase_sel_i & ~sect_prot_i;
    end

    // Next phase and capture strobes
    always_comb begin
        st_d         = st_q;
        cap_prog     = 1'b0;
        cap_erase    = 1'b0;
        fin_prog     = 1'b0;
        fin_erase    = 1'b0;
        tload_o      = 1'b0;
        tlen_erase_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (prog_start_i) begin
                    cap_prog = 1'b1;
                    st_d     = ST_PROG;
                    tload_o  = prog_prot;
                end else if (erase_start_i) begin
                    cap_erase = 1'b1;
                    st_d      = ST_ERASE;
                    if (erase_live == '0) begin
                        tload_o      = 1'b1;
                        tlen_erase_o = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (timer_act_i) begin
                    if (timer_exp_i) st_d = ST_IDLE;
                end else if (algo_done_i) begin
                    fin_prog = 1'b1;
                    st_d     = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (timer_act_i) begin
                    if (timer_exp_i) st_d = ST_IDLE;
                end else if (algo_done_i) begin
                    fin_erase = 1'b1;
                    st_d      = ST_IDLE;
                end else if (suspend_i) begin
                    st_d = ST_ESUSP;
                end
            end
            ST_ESUSP: begin
                if (prog_start_i) begin
                    cap_prog = 1'b1;
                    st_d     = ST_SPROG;
                    tload_o  = prog_prot;
                end else if (!suspend_i) begin
                    st_d = ST_ERASE;
                end
            end
            ST_SPROG: begin
                if (timer_act_i) begin
                    if (timer_exp_i) st_d = ST_ESUSP;
                end else if (algo_done_i) begin
                    fin_prog = 1'b1;
                    st_d     = ST_ESUSP;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase and captured command registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            paddr_q <= '0;
            pd7_q   <= 1'b0;
            esel_q  <= '0;
            emask_q <= '0;
            last_q  <= 1'b1;
        end else begin
            st_q <= st_d;
            if (cap_prog) begin
                paddr_q <= prog_addr_i;
                pd7_q   <= prog_d7_i;
            end
            if (cap_erase) begin
                esel_q  <= erase_sel_i;
                emask_q <= erase_live;
            end
            if (fin_prog)  last_q <= pd7_q;
            if (fin_erase) last_q <= 1'b1;
        end
    end

    // Captured state out to the read path
    always_comb begin
        state_o = st_q;
        paddr_o = paddr_q;
        pd7_o   = pd7_q;
        esel_o  = esel_q;
        emask_o = emask_q;
        last_o  = last_q;
    end

endmodule

// File: rtl/dq7_status_mux.sv
// Read-side decode. It compares the read address with the program target
// and with the erase selection, then picks status or the final value.
// Assumes: the sector is the top SECT_W bits of an address.
module dq7_status_mux
    import flash_dq7_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3,
    parameter int NSECT  = 1 << SECT_W
) (
    input  op_state_e         state_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic              pd7_i,
    input  logic [NSECT-1:0]  esel_i,
    input  logic [NSECT-1:0]  emask_i,
    input  logic              last_i,
    output logic              busy_o,
    output logic              status_sel_o,
    output logic              dq7_o,
    output logic [NSECT-1:0]  erase_sect_o
);

    localparam int SLO = ADDR_W - SECT_W;

    logic pmatch, in_esel, val;

    // Address hits against the captured command
    always_comb begin
        pmatch  = (rd_addr_i == paddr_i);
        in_esel = esel_i[rd_addr_i[ADDR_W-1:SLO]];
    end

    // Status selection and value per phase
    always_comb begin
        status_sel_o = 1'b0;
        val          = 1'b0;
        unique case (state_i)
            ST_PROG: begin
                status_sel_o = pmatch;
                val          = ~pd7_i;
            end
            ST_ERASE: begin
                status_sel_o = in_esel;
                val          = 1'b0;
            end
            ST_ESUSP: begin
                status_sel_o = in_esel;
                val          = 1'b1;
            end
            ST_SPROG: begin
                status_sel_o = pmatch | in_esel;
                val          = pmatch ? ~pd7_i : 1'b1;
            end
            default: begin
                status_sel_o = 1'b0;
                val          = 1'b0;
            end
        endcase
        dq7_o        = status_sel_o ? val : last_i;
        busy_o       = phase_busy(state_i);
        erase_sect_o = phase_erasing(state_i) ? emask_i : '0;
    end

endmodule

// File: rtl/flash_dq7_status.sv
// Top of the write-status polling bit generator. It joins the operation
// sequencer, the protected-window timer and the read-side decode. The two
// window lengths are given in clock cycles, and one timer serves both.
// Assumes: PROG_PROT_CYC and ERASE_PROT_CYC are at least 1.
module flash_dq7_status
    import flash_dq7_pkg::*;
#(
    parameter int ADDR_W         = 19,
    parameter int SECT_W         = 3,
    parameter int PROG_PROT_CYC  = 500,
    parameter int ERASE_PROT_CYC = 25000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_start_i,
    input  logic [ADDR_W-1:0]        prog_addr_i,
    input  logic                     prog_d7_i,
    input  logic                     erase_start_i,
    input  logic [(1<<SECT_W)-1:0]   erase_sel_i,
    input  logic                     algo_done_i,
    input  logic                     suspend_i,
    input  logic [(1<<SECT_W)-1:0]   sect_prot_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic                     busy_o,
    output logic                     status_sel_o,
    output logic                     dq7_o,
    output logic [(1<<SECT_W)-1:0]   erase_sect_o
);

    localparam int NSECT    = 1 << SECT_W;
    localparam int LONG_CYC = (PROG_PROT_CYC > ERASE_PROT_CYC) ? PROG_PROT_CYC : ERASE_PROT_CYC;
    localparam int CNT_W    = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LEN  = CNT_W'(PROG_PROT_CYC);
    localparam logic [CNT_W-1:0] ERASE_LEN = CNT_W'(ERASE_PROT_CYC);

    op_state_e         st;
    logic [ADDR_W-1:0] paddr;
    logic              pd7, last_val;
    logic [NSECT-1:0]  esel, emask;
    logic              tload, tlen_erase, timer_act, timer_exp;
    logic [CNT_W-1:0]  tlen;

    // Window length chosen by the kind of protected command
    always_comb tlen = tlen_erase ? ERASE_LEN : PROG_LEN;

    dq7_op_ctrl #(
        .ADDR_W(ADDR_W),
        .SECT_W(SECT_W),
        .NSECT (NSECT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_start_i (prog_start_i),
        .prog_addr_i  (prog_addr_i),
        .prog_d7_i    (prog_d7_i),
        .erase_start_i(erase_start_i),
        .erase_sel_i  (erase_sel_i),
        .algo_done_i  (algo_done_i),
        .suspend_i    (suspend_i),
        .sect_prot_i  (sect_prot_i),
        .timer_act_i  (timer_act),
        .timer_exp_i  (timer_exp),
        .state_o      (st),
        .paddr_o      (paddr),
        .pd7_o        (pd7),
        .esel_o       (esel),
        .emask_o      (emask),
        .last_o       (last_val),
        .tload_o      (tload),
        .tlen_erase_o (tlen_erase)
    );

    dq7_prot_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tload),
        .len_i   (tlen),
        .active_o(timer_act),
        .expire_o(timer_exp)
    );

    dq7_status_mux #(
        .ADDR_W(ADDR_W),
        .SECT_W(SECT_W),
        .NSECT (NSECT)
    ) u_mux (
        .state_i     (st),
        .rd_addr_i   (rd_addr_i),
        .paddr_i     (paddr),
        .pd7_i       (pd7),
        .esel_i      (esel),
        .emask_i     (emask),
        .last_i      (last_val),
        .busy_o      (busy_o),
        .status_sel_o(status_sel_o),
        .dq7_o       (dq7_o),
        .erase_sect_o(erase_sect_o)
    );

endmodule

// File: rtl/flash_dq7_status_chk.sv
// Property checker for the polling bit generator, bound to the top module.
module flash_dq7_status_chk
    import flash_dq7_pkg::*;
#(
    parameter int NSECT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_start_i,
    input logic             erase_start_i,
    input logic [NSECT-1:0] erase_sel_i,
    input logic [NSECT-1:0] sect_prot_i,
    input logic             algo_done_i,
    input logic             busy_o,
    input logic             status_sel_o,
    input logic             dq7_o,
    input logic [NSECT-1:0] erase_sect_o,
    input op_state_e        st,
    input logic             timer_act
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !status_sel_o && erase_sect_o == '0));

    // R2
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && prog_start_i) |=> busy_o);

    // R4
    erase_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && status_sel_o) |-> !dq7_o);

    // R5
    erase_done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && !timer_act && algo_done_i) |=> (!busy_o && dq7_o));

    // R6
    susp_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ESUSP) |-> !busy_o);

    // R10
    fake_erase_no_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && timer_act) |=> (st != ST_ESUSP));

    // R11
    erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !prog_start_i && erase_start_i)
        |=> (erase_sect_o == $past(erase_sel_i & ~sect_prot_i)));

    // R12
    prog_stays_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> (st != ST_ERASE && st != ST_ESUSP));

endmodule

bind flash_dq7_status flash_dq7_status_chk #(
    .NSECT(1 << SECT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_start_i (prog_start_i),
    .erase_start_i(erase_start_i),
    .erase_sel_i  (erase_sel_i),
    .sect_prot_i  (sect_prot_i),
    .algo_done_i  (algo_done_i),
    .busy_o       (busy_o),
    .status_sel_o (status_sel_o),
    .dq7_o        (dq7_o),
    .erase_sect_o (erase_sect_o),
    .st           (st),
    .timer_act    (timer_act)
);

// File: tb/test_flash_dq7_status.sv
`timescale 1ns/1ps
// Bench for the polling bit generator: a behavioural reference model is
// compared on every clock, alongside directed scenario checks.
module test_flash_dq7_status;

    localparam int AW = 12;
    localparam int SW = 2;
    localparam int NS = 4;
    localparam int PC = 20;
    localparam int EC = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0, prog_d7 = 1'b0, erase_start = 1'b0;
    logic          algo_done = 1'b0, suspend = 1'b0;
    logic [AW-1:0] prog_addr = '0, rd_addr = '0;
    logic [NS-1:0] erase_sel = '0, sect_prot = '0;
    logic          busy, ssel, dq7;
    logic [NS-1:0] esect;

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    flash_dq7_status #(
        .ADDR_W(AW), .SECT_W(SW), .PROG_PROT_CYC(PC), .ERASE_PROT_CYC(EC)
    ) i_flash_dq7_status (
        .clk(clk), .rst_n(rst_n),
        .prog_start_i(prog_start), .prog_addr_i(prog_addr), .prog_d7_i(prog_d7),
        .erase_start_i(erase_start), .erase_sel_i(erase_sel),
        .algo_done_i(algo_done), .suspend_i(suspend), .sect_prot_i(sect_prot),
        .rd_addr_i(rd_addr),
        .busy_o(busy), .status_sel_o(ssel), .dq7_o(dq7), .erase_sect_o(esect)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: 0 idle, 1 program, 2 erase, 3 suspended, 4 program in suspend
    int m_ph = 0, m_cnt = 0;
    bit m_fake = 0, m_pd = 0, m_last = 1;
    int m_pa = 0;
    bit [NS-1:0] m_sel = '0, m_msk = '0;

    function automatic int sec_of(input int a);
        return (a >> (AW - SW)) & (NS - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_fake = 0; m_pd = 0; m_last = 1;
            m_pa = 0; m_sel = '0; m_msk = '0;
        end else begin
            case (m_ph)
                0: if (prog_start) begin
                       m_pa = prog_addr; m_pd = prog_d7; m_ph = 1;
                       if (sect_prot[sec_of(prog_addr)]) begin m_fake = 1; m_cnt = PC; end
                   end else if (erase_start) begin
                       m_sel = erase_sel; m_msk = erase_sel & ~sect_prot; m_ph = 2;
                       if (m_msk == 0) begin m_fake = 1; m_cnt = EC; end
                   end
                1, 4: if (m_fake) begin
                       if (m_cnt == 1) begin m_fake = 0; m_cnt = 0; m_ph = (m_ph == 1) ? 0 : 3; end
                       else m_cnt--;
                   end else if (algo_done) begin
                       m_last = m_pd; m_ph = (m_ph == 1) ? 0 : 3;
                   end
                2: if (m_fake) begin
                       if (m_cnt == 1) begin m_fake = 0; m_cnt = 0; m_ph = 0; end
                       else m_cnt--;
                   end else if (algo_done) begin
                       m_last = 1; m_ph = 0;
                   end else if (suspend) m_ph = 3;
                3: if (prog_start) begin
                       m_pa = prog_addr; m_pd = prog_d7; m_ph = 4;
                       if (sect_prot[sec_of(prog_addr)]) begin m_fake = 1; m_cnt = PC; end
                   end else if (!suspend) m_ph = 2;
                default: m_ph = 0;
            endcase
        end
        #1;
        begin
            bit e_busy, e_sel, e_val, hit_p, hit_e;
            bit [NS-1:0] e_sect;
            hit_p  = (int'(rd_addr) == m_pa);
            hit_e  = m_sel[sec_of(int'(rd_addr))];
            e_busy = (m_ph == 1 || m_ph == 2 || m_ph == 4);
            e_sect = (m_ph >= 2) ? m_msk : '0;
            e_sel  = 0; e_val = 0;
            if (m_ph == 1) begin e_sel = hit_p; e_val = !m_pd; end
            if (m_ph == 2) begin e_sel = hit_e; e_val = 0; end
            if (m_ph == 3) begin e_sel = hit_e; e_val = 1; end
            if (m_ph == 4) begin e_sel = hit_p | hit_e; e_val = hit_p ? !m_pd : 1'b1; end
            chk({cur_req, " busy"}, busy, e_busy);
            chk({cur_req, " status_sel"}, ssel, e_sel);
            chk({cur_req, " dq7"}, dq7, e_sel ? e_val : m_last);
            chk({cur_req, " erase_sect"}, esect, e_sect);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic d);
        @(negedge clk); prog_start = 1; prog_addr = a; prog_d7 = d;
        @(negedge clk); prog_start = 0;
    endtask

    task automatic do_erase(input logic [NS-1:0] s);
        @(negedge clk); erase_start = 1; erase_sel = s;
        @(negedge clk); erase_start = 0;
    endtask

    task automatic done_pulse();
        @(negedge clk); algo_done = 1;
        @(negedge clk); algo_done = 0;
    endtask

    task automatic look(input logic [AW-1:0] a);
        rd_addr = a; #0.5;
    endtask

    initial begin
        int n;
        cyc(3);
        cur_req = "R1";
        chk("R1 busy in reset", busy, 0);
        chk("R1 sel in reset", ssel, 0);
        chk("R1 dq7 in reset", dq7, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sect after reset", esect, 0);

        cur_req = "R8";
        for (int i = 0; i < 8; i++) begin
            look(AW'(i * 517)); chk("R8 idle sel", ssel, 0);
        end

        cur_req = "R2";
        look(12'h123);
        do_prog(12'h123, 1'b1);
        chk("R2 busy", busy, 1);
        chk("R2 sel at target", ssel, 1);
        chk("R2 complement", dq7, 0);
        look(12'h124); chk("R2 other addr sel", ssel, 0);
        look(12'h123); cyc(4);
        cur_req = "R3";
        done_pulse();
        chk("R3 busy", busy, 0);
        chk("R3 sel", ssel, 0);
        chk("R3 true datum 1", dq7, 1);
        look(12'h456);
        do_prog(12'h456, 1'b0);
        chk("R2 complement of 0", dq7, 1);
        done_pulse();
        chk("R3 true datum 0", dq7, 0);

        cur_req = "R4";
        do_erase(4'b0110);
        look(12'h500); chk("R4 sel in sector", ssel, 1); chk("R4 reads 0", dq7, 0);
        look(12'h050); chk("R4 outside sel", ssel, 0);
        chk("R4 mask", esect, 4'b0110);
        cyc(3);
        cur_req = "R5";
        done_pulse();
        chk("R5 busy", busy, 0);
        chk("R5 dq7", dq7, 1);

        cur_req = "R6";
        do_erase(4'b0010);
        cyc(3);
        suspend = 1; cyc(2);
        look(12'h410);
        chk("R6 busy in suspend", busy, 0);
        chk("R6 sel", ssel, 1);
        chk("R6 reads 1", dq7, 1);
        cur_req = "R7";
        look(12'hC20);
        do_prog(12'hC20, 1'b0);
        chk("R7 busy", busy, 1);
        chk("R7 complement", dq7, 1);
        look(12'h410); chk("R7 erase sector reads 1", dq7, 1);
        done_pulse();
        chk("R7 back to suspend", busy, 0);
        look(12'hC20); chk("R7 sel after", ssel, 0); chk("R7 true datum", dq7, 0);
        cur_req = "R6";
        suspend = 0; cyc(2);
        look(12'h410);
        chk("R6 resumed busy", busy, 1);
        chk("R6 resumed reads 0", dq7, 0);
        done_pulse();

        cur_req = "R9";
        sect_prot = 4'b0100;
        look(12'h820);
        do_prog(12'h820, 1'b1);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (n == 3) algo_done = 1;
            if (n == 4) algo_done = 0;
            @(negedge clk);
        end
        chk("R9 window length", n, PC);
        chk("R9 dq7 unchanged", dq7, 1);

        cur_req = "R10";
        sect_prot = 4'b0110;
        do_erase(4'b0110);
        suspend = 1;
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R10 window length", n, EC);
        suspend = 0;
        cyc(1);

        cur_req = "R11";
        sect_prot = 4'b0100;
        do_erase(4'b0110);
        chk("R11 mask", esect, 4'b0010);
        look(12'h830); chk("R11 protected sel", ssel, 1); chk("R11 protected reads 0", dq7, 0);
        cyc(EC + 10);
        chk("R11 still busy", busy, 1);
        done_pulse();
        chk("R11 ended", busy, 0);

        cur_req = "R12";
        sect_prot = '0;
        do_prog(12'h111, 1'b1);
        do_erase(4'b1111);
        chk("R12 erase ignored", esect, 0);
        do_prog(12'h222, 1'b0);
        look(12'h222); chk("R12 new addr ignored", ssel, 0);
        look(12'h111); chk("R12 old addr kept", ssel, 1);
        done_pulse();
        @(negedge clk); prog_start = 1; erase_start = 1; prog_addr = 12'h333; erase_sel = 4'b1111;
        @(negedge clk); prog_start = 0; erase_start = 0;
        chk("R12 program wins", esect, 0);
        look(12'h333); chk("R12 program wins sel", ssel, 1);
        done_pulse();
        cyc(2);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule